// File: doc/BRIEF.md
# Interrupt Source P/Q State Bank

This block keeps a two-bit state pair for each interrupt source in a bank. P stands for "pending" and Q for "queued". Source trigger events arrive on their own port. Each event either produces a notification toward the routing stage, is coalesced into Q, or is dropped. Software reaches the same state through load and store requests aimed at a per-source management page. The operation is chosen by the page offset. A load returns the state as it was before the access and applies the change in the same cycle.

Encodings: 00 is idle and enabled, 01 is fully masked, 10 is pending or temporarily masked, and 11 is pending with one more occurrence recorded. The bank is configured per source through parameters. Each source can be edge or level-sensitive, can have a 4 KiB or 64 KiB page, and can use the offset quirk, in which every management offset is moved up by four bits. Each source can also support store-EOI replay or not, and can have a separate trigger page or not. The notify output is a vector with one bit per source, so sources that fire in the same cycle do not block each other. A store request carries no data.

Top module: `irq_pq_bank`

## Requirements
- R1: After reset every source holds 01, `notify` is all zero and `rsp_valid` is low.
- R2: An edge trigger in state 00 moves the source to 10 and raises that source's `notify` bit for exactly one cycle, in the cycle after the trigger.
- R3: An edge trigger in state 10 or 11 leaves 11 and raises no notify. An edge trigger in state 01 changes nothing.
- R4: EOI sets P to the old Q and clears Q, and raises notify when the new P is 1. An EOI is a load at operation nibble 0xC on any source, or a store at nibble 0xC on a store-EOI source. The EOI load returns {0, old P}.
- R5: A load at operation nibble 0xD returns {P,Q} in bits [1:0] and changes nothing.
- R6: A load at operation nibble 0xE returns the old {P,Q} and writes the value found in offset bits [5:4] (0xE00→00, 0xE10→01, 0xE20→10, 0xE30→11). It raises no notify.
- R7: The operation nibble is offset bits [11:8] for a normal source. For a quirk source it is bits [15:12], and the set value for such a source is in bits [9:8].
- R8: On a 4 KiB source, an offset of 0x1000 or above changes nothing and a load there returns 11. On a 64 KiB source the same offset is decoded normally.
- R9: A store that is not a store-EOI acts as a trigger when the source has no separate trigger page. When the source has a separate trigger page, the store is ignored.
- R10: On a level-sensitive source Q is ignored. A trigger with P=0 sets P and notifies, even from 01. A trigger with P=1 does nothing. EOI clears P, leaves Q and never notifies.
- R11: A load at any other operation nibble returns 11 and changes nothing.
- R12: When a request and a trigger hit the same source in one cycle, the request takes effect first and the trigger then acts on the result. Requests and triggers to different sources in the same cycle both take effect.
- R13: `rsp_valid` goes high exactly one cycle after a load and never after a store or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger event from a source |
| trig_src | input | SRCW | Index of the triggering source |
| req_valid | input | 1 | Management-page access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_src | input | SRCW | Source whose page is accessed |
| req_off | input | 16 | Byte offset inside the page |
| rsp_valid | output | 1 | Load response valid |
| rsp_pq | output | 2 | Load response data |
| notify | output | NSRC | One-cycle notification pulse per source |

## Verification
A wrong internal state cannot stay hidden for long. The next get load on that source shows it one cycle after the load. The next trigger also exposes it, by raising notify when it should not or by failing to raise it. A bad coalesce or a lost Q shows up when the next EOI replays wrongly, again one cycle after the access. Decode faults in offset shifting or the page bound appear directly in the load data.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

  localparam int OFFW = 16;

  typedef enum logic [2:0] {
    OP_NONE, OP_EOI, OP_GET, OP_SET, OP_TRIG, OP_SEOI
  } pq_op_e;

  localparam logic [3:0] NIB_EOI = 4'hC;
  localparam logic [3:0] NIB_GET = 4'hD;
  localparam logic [3:0] NIB_SET = 4'hE;

  // Offset as seen by the decoder after undoing the quirk shift.
  function automatic logic [OFFW-1:0] pq_norm_off(logic [OFFW-1:0] off, logic quirk);
    return quirk ? (off >> 4) : off;
  endfunction

  function automatic logic [3:0] pq_op_nibble(logic [OFFW-1:0] noff);
    return 4'((noff & 16'h0F00) >> 8);
  endfunction

  function automatic logic [1:0] pq_set_value(logic [OFFW-1:0] noff);
    return 2'((noff & 16'h0030) >> 4);
  endfunction

  function automatic logic pq_in_page(logic [OFFW-1:0] off, logic big);
    return big || ((off & 16'hF000) == 16'h0000);
  endfunction

  // Returns {fire, next_pq}
  function automatic logic [2:0] pq_trigger(logic [1:0] pq, logic lsi);
    if (lsi) return pq[1] ? {1'b0, pq} : {1'b1, 1'b1, pq[0]};
    case (pq)
      2'b00:   return {1'b1, 2'b10};
      2'b01:   return {1'b0, 2'b01};
      default: return {1'b0, 2'b11};
    endcase
  endfunction

  // Returns {fire, next_pq}
  function automatic logic [2:0] pq_eoi(logic [1:0] pq, logic lsi);
    if (lsi) return {1'b0, 1'b0, pq[0]};
    return {pq[0], pq[0], 1'b0};
  endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
  import irq_pq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SRCW = 3,
  parameter logic [NSRC-1:0] QUIRK_SET  = '0,
  parameter logic [NSRC-1:0] BIG_SET    = '0,
  parameter logic [NSRC-1:0] STEOI_SET  = '0,
  parameter logic [NSRC-1:0] TRIGPG_SET = '0
) (
  input  logic            req_write,
  input  logic [SRCW-1:0] req_src,
  input  logic [OFFW-1:0] req_off,
  output pq_op_e          dec_op,
  output logic [1:0]      dec_set
);

  logic [OFFW-1:0] noff;
  logic [3:0]      nib;
  logic            in_page;

  always_comb begin
    noff    = pq_norm_off(req_off, QUIRK_SET[req_src]);
    nib     = pq_op_nibble(noff);
    dec_set = pq_set_value(noff);
    in_page = pq_in_page(req_off, BIG_SET[req_src]);
    dec_op  = OP_NONE;
    if (in_page) begin
      if (!req_write) begin
        case (nib)
          NIB_EOI: dec_op = OP_EOI;
          NIB_GET: dec_op = OP_GET;
          NIB_SET: dec_op = OP_SET;
          default: dec_op = OP_NONE;
        endcase
      end else if (nib == NIB_EOI && STEOI_SET[req_src]) begin
        dec_op = OP_SEOI;
      end else if (!TRIGPG_SET[req_src]) begin
        dec_op = OP_TRIG;
      end
    end
  end

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
  import irq_pq_pkg::*;
#(
  parameter bit LSI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_hit,
  input  pq_op_e     op,
  input  logic [1:0] set_val,
  input  logic       trig_hit,
  output logic [1:0] pq_q,
  output logic       fire_q
);

  logic [1:0] s_req, s_nxt;
  logic       f_req, f_trig;
  logic       is_eoi;
  logic       replay_evt;
  logic       coalesce_evt;

  assign is_eoi = req_hit && (op == OP_EOI || op == OP_SEOI);

  always_comb begin
    s_req = pq_q;
    f_req = 1'b0;
    if (req_hit) begin
      case (op)
        OP_EOI, OP_SEOI: {f_req, s_req} = pq_eoi(pq_q, LSI);
        OP_SET:          s_req = set_val;
        OP_TRIG:         {f_req, s_req} = pq_trigger(pq_q, LSI);
        default:         s_req = pq_q;
      endcase
    end
    if (trig_hit) {f_trig, s_nxt} = pq_trigger(s_req, LSI);
    else          {f_trig, s_nxt} = {1'b0, s_req};
  end

  assign replay_evt   = is_eoi && f_req;
  assign coalesce_evt = trig_hit && !LSI && s_req[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q   <= 2'b01;
      fire_q <= 1'b0;
    end else begin
      pq_q   <= s_nxt;
      fire_q <= f_req | f_trig;
    end
  end

  // R2: a notification always leaves P set
  a_r2_fire_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> pq_q[1]);

  if (LSI) begin : g_lsi
    a_r10_q_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit && !req_hit |=> pq_q[0] == $past(pq_q[0]));
    a_r10_eoi_silent: assert property (@(posedge clk) disable iff (!rst_n)
      is_eoi && !trig_hit |=> !fire_q && !pq_q[1]);
  end else begin : g_edge
    a_r2_idle_fires: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit && !req_hit && pq_q == 2'b00 |=> pq_q == 2'b10 && fire_q);
    a_r3_coalesce: assert property (@(posedge clk) disable iff (!rst_n)
      coalesce_evt && !req_hit |=> pq_q == 2'b11 && !fire_q);
    a_r3_masked_drop: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit && !req_hit && pq_q == 2'b01 |=> pq_q == 2'b01 && !fire_q);
    a_r4_eoi_replay: assert property (@(posedge clk) disable iff (!rst_n)
      is_eoi && !trig_hit |=> pq_q[1] == $past(pq_q[0]) && !pq_q[0]
                              && fire_q == $past(replay_evt));
  end

endmodule

// File: rtl/irq_pq_bank.sv
module irq_pq_bank
  import irq_pq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter logic [NSRC-1:0] LSI_SET    = 8'b0000_1000,
  parameter logic [NSRC-1:0] QUIRK_SET  = 8'b0001_0000,
  parameter logic [NSRC-1:0] BIG_SET    = 8'b0011_0000,
  parameter logic [NSRC-1:0] STEOI_SET  = 8'b1111_1001,
  parameter logic [NSRC-1:0] TRIGPG_SET = 8'b0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_valid,
  input  logic [SRCW-1:0] trig_src,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [SRCW-1:0] req_src,
  input  logic [15:0]     req_off,
  output logic            rsp_valid,
  output logic [1:0]      rsp_pq,
  output logic [NSRC-1:0] notify
);

  pq_op_e     dec_op;
  logic [1:0] dec_set;
  logic [1:0] pq_all [NSRC];
  logic [1:0] old_pq;
  logic [1:0] rsp_d;

  irq_pq_decode #(
    .NSRC(NSRC), .SRCW(SRCW), .QUIRK_SET(QUIRK_SET), .BIG_SET(BIG_SET),
    .STEOI_SET(STEOI_SET), .TRIGPG_SET(TRIGPG_SET)
  ) dec_i (
    .req_write(req_write), .req_src(req_src), .req_off(req_off),
    .dec_op(dec_op), .dec_set(dec_set)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic req_hit_i, trig_hit_i;
    assign req_hit_i  = req_valid && (dec_op != OP_NONE) && (req_src == SRCW'(i));
    assign trig_hit_i = trig_valid && (trig_src == SRCW'(i));
    irq_pq_cell #(.LSI(LSI_SET[i])) cell_i (
      .clk(clk), .rst_n(rst_n), .req_hit(req_hit_i), .op(dec_op),
      .set_val(dec_set), .trig_hit(trig_hit_i),
      .pq_q(pq_all[i]), .fire_q(notify[i])
    );
  end

  assign old_pq = pq_all[req_src];

  always_comb begin
    case (dec_op)
      OP_EOI:         rsp_d = {1'b0, old_pq[1]};
      OP_GET, OP_SET: rsp_d = old_pq;
      default:        rsp_d = 2'b11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pq    <= 2'b00;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_pq    <= rsp_d;
    end
  end

  // R13: responses follow loads only
  a_r13_rsp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R13: every load is answered
  a_r13_load_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);

endmodule

// File: tb/irq_pq_bank_tb.sv
module irq_pq_bank_tb_top;

  localparam int NSRC = 8;
  localparam logic [1:0] K_TRG = 2'd0, K_LD = 2'd1, K_ST = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [2:0] trig_src = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_src = '0;
  logic [15:0] req_off = '0;
  logic rsp_valid;
  logic [1:0] rsp_pq;
  logic [NSRC-1:0] notify;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  irq_pq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_src(trig_src),
    .req_valid(req_valid), .req_write(req_write), .req_src(req_src),
    .req_off(req_off), .rsp_valid(rsp_valid), .rsp_pq(rsp_pq), .notify(notify)
  );

  // {req#[28:25], kind[24:23], src[22:20], off[19:4], rsp_valid[3], rsp[2:1], notify[0]}
  localparam int NV = 42;
  localparam logic [28:0] VEC [NV] = '{
    {4'd1,  K_LD,  3'd0, 16'h0D00, 1'b1, 2'b01, 1'b0}, // R1 reset 01
    {4'd3,  K_TRG, 3'd0, 16'h0000, 1'b0, 2'b00, 1'b0}, // R3 masked drop
    {4'd6,  K_LD,  3'd0, 16'h0E00, 1'b1, 2'b01, 1'b0}, // R6 set 00
    {4'd2,  K_TRG, 3'd0, 16'h0000, 1'b0, 2'b00, 1'b1}, // R2 fire
    {4'd3,  K_TRG, 3'd0, 16'h0000, 1'b0, 2'b00, 1'b0}, // R3 coalesce
    {4'd5,  K_LD,  3'd0, 16'h0D00, 1'b1, 2'b11, 1'b0}, // R5 get 11
    {4'd4,  K_ST,  3'd0, 16'h0C00, 1'b0, 2'b00, 1'b1}, // R4 store-EOI replay
    {4'd4,  K_ST,  3'd0, 16'h0C00, 1'b0, 2'b00, 1'b0}, // R4 store-EOI no replay
    {4'd5,  K_LD,  3'd0, 16'h0D00, 1'b1, 2'b00, 1'b0}, // R5
    {4'd6,  K_LD,  3'd0, 16'h0E20, 1'b1, 2'b00, 1'b0}, // R6 set 10
    {4'd4,  K_LD,  3'd0, 16'h0C00, 1'b1, 2'b01, 1'b0}, // R4 EOI load old P
    {4'd6,  K_LD,  3'd0, 16'h0E30, 1'b1, 2'b00, 1'b0}, // R6 set 11
    {4'd4,  K_LD,  3'd0, 16'h0C00, 1'b1, 2'b01, 1'b1}, // R4 EOI load replays
    {4'd11, K_LD,  3'd0, 16'h0F00, 1'b1, 2'b11, 1'b0}, // R11 unknown op
    {4'd11, K_LD,  3'd0, 16'h0D00, 1'b1, 2'b10, 1'b0}, // R11 unchanged
    {4'd8,  K_LD,  3'd0, 16'h1D00, 1'b1, 2'b11, 1'b0}, // R8 outside 4K page
    {4'd8,  K_LD,  3'd0, 16'h0D00, 1'b1, 2'b10, 1'b0}, // R8 unchanged
    {4'd6,  K_LD,  3'd1, 16'h0E00, 1'b1, 2'b01, 1'b0}, // R6 src1 set 00
    {4'd9,  K_ST,  3'd1, 16'h0C00, 1'b0, 2'b00, 1'b1}, // R9 store acts as trigger
    {4'd9,  K_ST,  3'd1, 16'h0000, 1'b0, 2'b00, 1'b0}, // R9 trigger coalesces
    {4'd9,  K_LD,  3'd1, 16'h0D00, 1'b1, 2'b11, 1'b0}, // R9
    {4'd6,  K_LD,  3'd2, 16'h0E00, 1'b1, 2'b01, 1'b0}, // R6 src2 set 00
    {4'd9,  K_ST,  3'd2, 16'h0C00, 1'b0, 2'b00, 1'b0}, // R9 trigger page: ignored
    {4'd9,  K_LD,  3'd2, 16'h0D00, 1'b1, 2'b00, 1'b0}, // R9 still 00
    {4'd9,  K_ST,  3'd0, 16'h0400, 1'b0, 2'b00, 1'b0}, // R9 other offset triggers
    {4'd9,  K_LD,  3'd0, 16'h0D00, 1'b1, 2'b11, 1'b0}, // R9
    {4'd10, K_TRG, 3'd3, 16'h0000, 1'b0, 2'b00, 1'b1}, // R10 LSI fires from 01
    {4'd10, K_TRG, 3'd3, 16'h0000, 1'b0, 2'b00, 1'b0}, // R10 P set: nothing
    {4'd10, K_LD,  3'd3, 16'h0D00, 1'b1, 2'b11, 1'b0}, // R10 Q kept
    {4'd10, K_LD,  3'd3, 16'h0C00, 1'b1, 2'b01, 1'b0}, // R10 EOI no replay
    {4'd10, K_LD,  3'd3, 16'h0D00, 1'b1, 2'b01, 1'b0}, // R10
    {4'd10, K_LD,  3'd3, 16'h0E20, 1'b1, 2'b01, 1'b0}, // R10 mask with P
    {4'd10, K_TRG, 3'd3, 16'h0000, 1'b0, 2'b00, 1'b0}, // R10 masked by P
    {4'd10, K_LD,  3'd3, 16'h0D00, 1'b1, 2'b10, 1'b0}, // R10
    {4'd7,  K_LD,  3'd4, 16'h0D00, 1'b1, 2'b11, 1'b0}, // R7 unshifted offset unknown
    {4'd7,  K_LD,  3'd4, 16'hD000, 1'b1, 2'b01, 1'b0}, // R7 shifted get
    {4'd7,  K_LD,  3'd4, 16'hE000, 1'b1, 2'b01, 1'b0}, // R7 shifted set 00
    {4'd2,  K_TRG, 3'd4, 16'h0000, 1'b0, 2'b00, 1'b1}, // R2
    {4'd7,  K_LD,  3'd4, 16'hE300, 1'b1, 2'b10, 1'b0}, // R7 shifted set 11
    {4'd7,  K_ST,  3'd4, 16'hC000, 1'b0, 2'b00, 1'b1}, // R7 shifted store-EOI
    {4'd7,  K_LD,  3'd4, 16'hD000, 1'b1, 2'b10, 1'b0}, // R7
    {4'd8,  K_LD,  3'd5, 16'h1D00, 1'b1, 2'b01, 1'b0}  // R8 64K page in range
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_op(input logic [1:0] kind, input logic [2:0] src, input logic [15:0] off);
    @(negedge clk);
    trig_valid = (kind == K_TRG);
    trig_src   = src;
    req_valid  = (kind != K_TRG);
    req_write  = (kind == K_ST);
    req_src    = src;
    req_off    = off;
    @(negedge clk);
    trig_valid = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset outputs
    chk(notify == '0 && !rsp_valid, "R1 reset outputs", {notify, rsp_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [NSRC-1:0] exp_n;
      drive_op(VEC[v][24:23], VEC[v][22:20], VEC[v][19:4]);
      exp_n = VEC[v][0] ? (NSRC'(1) << VEC[v][22:20]) : '0;
      chk(rsp_valid == VEC[v][3] && (!VEC[v][3] || rsp_pq == VEC[v][2:1]) && notify == exp_n,
          $sformatf("R%0d vector %0d", VEC[v][28:25], v),
          {rsp_valid, rsp_pq, notify}, {VEC[v][3], VEC[v][2:1], exp_n});
    end

    // R12 request then trigger on one source in one cycle: src6 01 -> set 00 -> trigger fires
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_src = 3'd6; req_off = 16'h0E00;
    trig_valid = 1'b1; trig_src = 3'd6;
    @(negedge clk);
    req_valid = 1'b0; trig_valid = 1'b0;
    chk(rsp_valid && rsp_pq == 2'b01 && notify == 8'h40, "R12 same-source order",
        {rsp_valid, rsp_pq, notify}, {1'b1, 2'b01, 8'h40});
    drive_op(K_LD, 3'd6, 16'h0D00);
    chk(rsp_pq == 2'b10, "R12 same-source state", rsp_pq, 2'b10);

    // R12 two sources at once: src0 11 store-EOI replays, src7 00 trigger fires
    drive_op(K_LD, 3'd7, 16'h0E00);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_src = 3'd0; req_off = 16'h0C00;
    trig_valid = 1'b1; trig_src = 3'd7;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; trig_valid = 1'b0;
    chk(notify == 8'h81 && !rsp_valid, "R12 two-source notify", {rsp_valid, notify}, 8'h81);

    // R13 idle cycle gives no response and notify drops after one cycle (R2)
    @(negedge clk);
    chk(!rsp_valid, "R13 idle no response", rsp_valid, 0);
    chk(notify == '0, "R2 single-cycle pulse", notify, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule